// File: doc/BRIEF.md
# Frame Sync and Error Flag Output

This block divides the system clock down to a square wave with one period per data frame, 7.35 kHz from a 16.9344 MHz clock with the default divider. The same frame timing is used to share one flag pin between two error-correction stages. While the sync output is low, the flag describes how the first decoder stage handled the current frame. While the sync output is high, it describes the second stage. Each stage reports a two-bit status code. The flag turns that code into a pattern that a host can read by counting high pulses in each half-frame.

The stage codes are captured into registers at the half-frame boundaries, so the flag pattern stays fixed for a whole half-frame. A host command byte can force both outputs low, and a second command byte releases them. The divider keeps running while the outputs are forced low, so frame phase is kept.

Top module: `frame_sync_flag`

## Requirements
- R1: `fsync_o` has a period of FRAME_DIV clocks. It is low for the first FRAME_DIV/2 and high for the last FRAME_DIV/2. The first output value after reset release is the first clock of a low half.
- R2: During the low half, `eflag_o` shows the latched first-stage code. During the high half, it shows the latched second-stage code.
- R3: Code 2'b00 (no errors) keeps `eflag_o` low for the whole half.
- R4: Code 2'b01 (one correction) gives one high pulse of PULSE_LEN clocks. The pulse starts PULSE_LEN clocks into the half.
- R5: Code 2'b10 (two corrections) gives the pulse of R4 and a second pulse of PULSE_LEN clocks that starts 3*PULSE_LEN clocks into the half.
- R6: Code 2'b11 (uncorrectable) holds `eflag_o` high for the entire half.
- R7: The first-stage input is sampled only on the last clock of a frame. The second-stage input is sampled only on the last clock of the low half. Input changes at any other time have no effect on the flag.
- R8: `cmd_valid` with `cmd_byte` 8'h0A forces both outputs low from the second clock edge after the command. The divider keeps counting.
- R9: `cmd_valid` with `cmd_byte` 8'h0B restores normal outputs from the second clock edge after the command, with the frame phase unchanged.
- R10: Any other command byte, or any byte while `cmd_valid` is low, leaves the output state unchanged.
- R11: Reset has the following effects:
  - Both outputs are low while reset is asserted.
  - The outputs are enabled after reset.
  - Both latched codes reset to no errors, so the first low half after reset shows a low flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| c1_status | input | 2 | First-stage correction code for the frame |
| c2_status | input | 2 | Second-stage correction code for the frame |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Host command byte |
| fsync_o | output | 1 | Frame sync square wave |
| eflag_o | output | 1 | Multiplexed correction flag |

## Verification
The assertions check the following on every cycle:
- the divider wrap;
- that each latched stage code holds between its sampling points;
- that the enable state changes only on a recognised command;
- that the sync output follows the counter phase while enabled;
- that both outputs fall after the enable drops.

Only the bench scenarios can show the exact pulse placement and pulse count for each code in each half. The same holds for the choice between the first and second stage by phase. The bench scenarios also cover the rejection of input changes mid-frame, the two-edge command latency, and the preserved phase after the outputs are released.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  typedef enum logic [1:0] {
    CORR_NONE   = 2'b00,
    CORR_SINGLE = 2'b01,
    CORR_DOUBLE = 2'b10,
    CORR_LOST   = 2'b11
  } corr_e;
endpackage

// File: rtl/fsf_divider.sv
module fsf_divider #(
  parameter int unsigned FRAME_DIV = 2304,
  localparam int unsigned CW = $clog2(FRAME_DIV),
  localparam int unsigned HALF = FRAME_DIV / 2
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hi_phase,
  output logic [CW-1:0] hpos,
  output logic [1:0]    load_stage
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FRAME_DIV - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    hi_phase      = (cnt_q >= CW'(HALF));
    hpos          = hi_phase ? (cnt_q - CW'(HALF)) : cnt_q;
    load_stage[0] = (cnt_q == CW'(FRAME_DIV - 1));
    load_stage[1] = (cnt_q == CW'(HALF - 1));
  end

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(FRAME_DIV - 1)) |=> (cnt_q == '0));
endmodule

// File: rtl/fsf_status_latch.sv
module fsf_status_latch
  import fsf_pkg::*;
#(
  parameter int unsigned NSTAGE = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSTAGE-1:0]     load_stage,
  input  logic [NSTAGE-1:0][1:0] stage_in,
  input  logic                  hi_phase,
  output corr_e                 sel_st
);
  corr_e st_q [NSTAGE];

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g] <= CORR_NONE;
      end else if (load_stage[g]) begin
        st_q[g] <= corr_e'(stage_in[g]);
      end
    end

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load_stage[g] |=> $stable(st_q[g]));
  end

  assign sel_st = hi_phase ? st_q[1] : st_q[0];
endmodule

// File: rtl/fsf_flag_shaper.sv
module fsf_flag_shaper
  import fsf_pkg::*;
#(
  parameter int unsigned FRAME_DIV = 2304,
  parameter int unsigned PULSE_LEN = 64,
  localparam int unsigned CW = $clog2(FRAME_DIV)
) (
  input  corr_e         st,
  input  logic [CW-1:0] hpos,
  output logic          flag
);
  localparam int unsigned P1_BEG = PULSE_LEN;
  localparam int unsigned P1_END = 2 * PULSE_LEN;
  localparam int unsigned P2_BEG = 3 * PULSE_LEN;
  localparam int unsigned P2_END = 4 * PULSE_LEN;

  logic in_p1, in_p2;

  always_comb begin
    in_p1 = (hpos >= CW'(P1_BEG)) && (hpos < CW'(P1_END));
    in_p2 = (hpos >= CW'(P2_BEG)) && (hpos < CW'(P2_END));
    unique case (st)
      CORR_NONE:   flag = 1'b0;
      CORR_SINGLE: flag = in_p1;
      CORR_DOUBLE: flag = in_p1 | in_p2;
      CORR_LOST:   flag = 1'b1;
      default:     flag = 1'b0;
    endcase
  end
endmodule

// File: rtl/fsf_cmd_gate.sv
module fsf_cmd_gate #(
  parameter logic [7:0] CMD_MUTE   = 8'h0A,
  parameter logic [7:0] CMD_UNMUTE = 8'h0B
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b1;
    end else if (cmd_valid) begin
      if (cmd_byte == CMD_MUTE)        en_q <= 1'b0;
      else if (cmd_byte == CMD_UNMUTE) en_q <= 1'b1;
    end
  end

  // R10
  ignore_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && (cmd_byte == CMD_MUTE || cmd_byte == CMD_UNMUTE)) |=> $stable(en_q));
endmodule

// File: rtl/frame_sync_flag.sv
module frame_sync_flag
  import fsf_pkg::*;
#(
  parameter int unsigned FRAME_DIV  = 2304,
  parameter int unsigned PULSE_LEN  = 64,
  parameter logic [7:0]  CMD_MUTE   = 8'h0A,
  parameter logic [7:0]  CMD_UNMUTE = 8'h0B
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] c1_status,
  input  logic [1:0] c2_status,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       fsync_o,
  output logic       eflag_o
);
  localparam int unsigned CW = $clog2(FRAME_DIV);

  logic          hi_phase;
  logic [CW-1:0] hpos;
  logic [1:0]    load_stage;
  corr_e         sel_st;
  logic          flag;
  logic          en_q;

  fsf_divider #(.FRAME_DIV(FRAME_DIV)) u_div (
    .clk        (clk),
    .rst        (rst),
    .hi_phase   (hi_phase),
    .hpos       (hpos),
    .load_stage (load_stage)
  );

  fsf_status_latch #(.NSTAGE(2)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .load_stage (load_stage),
    .stage_in   ({c2_status, c1_status}),
    .hi_phase   (hi_phase),
    .sel_st     (sel_st)
  );

  fsf_flag_shaper #(.FRAME_DIV(FRAME_DIV), .PULSE_LEN(PULSE_LEN)) u_shape (
    .st   (sel_st),
    .hpos (hpos),
    .flag (flag)
  );

  fsf_cmd_gate #(.CMD_MUTE(CMD_MUTE), .CMD_UNMUTE(CMD_UNMUTE)) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .en_q      (en_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fsync_o <= 1'b0;
      eflag_o <= 1'b0;
    end else begin
      fsync_o <= en_q & hi_phase;
      eflag_o <= en_q & flag;
    end
  end

  // R8
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (!fsync_o && !eflag_o));

  // R1
  phase_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && hi_phase) |=> fsync_o);
endmodule

// File: tb/frame_sync_flag_tb.sv
`timescale 1ns/1ps
module frame_sync_flag_tb;
  localparam int DIV  = 2304;
  localparam int HALF = DIV / 2;
  localparam int P    = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] c1_status = 2'b00;
  logic [1:0] c2_status = 2'b00;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       fsync_o, eflag_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int k = 0;

  always #2.5 clk = ~clk;

  frame_sync_flag u_dut (
    .clk(clk), .rst(rst), .c1_status(c1_status), .c2_status(c2_status),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .fsync_o(fsync_o), .eflag_o(eflag_o)
  );

  always @(posedge clk) begin
    if (rst) k <= 0;
    else     k <= k + 1;
  end

  function automatic int cur_m();
    return (k == 0) ? -1 : (k - 1) % DIV;
  endfunction

  function automatic bit exp_flag(int m, int c1, int c2);
    int hp = (m < HALF) ? m : m - HALF;
    int st = (m < HALF) ? c1 : c2;
    bit p1 = (hp >= P) && (hp < 2 * P);
    bit p2 = (hp >= 3 * P) && (hp < 4 * P);
    case (st)
      0: return 1'b0;
      1: return p1;
      2: return p1 | p2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_m(int t);
    do @(negedge clk); while (cur_m() != t);
  endtask

  // Checks one whole frame; glitches the inputs between sampling points
  task automatic frame_case(int c1, int c2, string tag);
    int bad_fs = 0, bad_fl = 0, first_act = 0, first_exp = 0;
    wait_m(HALF + 10);
    c1_status = 2'(c1);
    c2_status = 2'(c2);
    wait_m(0);
    for (int i = 0; i < DIV; i++) begin
      if (i > 0) @(negedge clk);
      if (fsync_o !== (i >= HALF)) bad_fs++;
      if (eflag_o !== exp_flag(i, c1, c2)) begin
        if (bad_fl == 0) begin first_act = i; first_exp = int'(exp_flag(i, c1, c2)); end
        bad_fl++;
      end
      if (i == 100) c1_status = ~2'(c1);
      if (i == HALF + 100) begin c1_status = ~2'(c1); c2_status = ~2'(c2); end
    end
    chk(bad_fs == 0, "R1 fsync shape", bad_fs, 0);
    chk(bad_fl == 0, {tag, " flag pattern (mismatch count, first at cycle ", $sformatf("%0d exp %0d)", first_act, first_exp)}, bad_fl, 0);
  endtask

  task automatic t_reset();
    int bad = 0;
    c1_status = 2'b11; c2_status = 2'b11;
    repeat (4) @(negedge clk);
    chk(fsync_o == 1'b0 && eflag_o == 1'b0, "R11 outputs low in reset", {fsync_o, eflag_o}, 0);
    rst = 1'b0;
    wait_m(0);
    for (int i = 0; i < HALF; i++) begin
      if (i > 0) @(negedge clk);
      if (fsync_o !== 1'b0 || eflag_o !== 1'b0) bad++;
    end
    chk(bad == 0, "R11 first low half: sync low, code reset to no errors", bad, 0);
    @(negedge clk);
    chk(fsync_o == 1'b1, "R1 sync rises after half period", fsync_o, 1);
  endtask

  task automatic send_cmd(logic [7:0] b, logic v);
    cmd_valid = v; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_byte = 8'h00;
  endtask

  task automatic t_mute();
    int bad = 0;
    wait_m(HALF + 10);
    c1_status = 2'b11; c2_status = 2'b11;
    send_cmd(8'h0A, 1'b1);
    chk(fsync_o == 1'b1, "R8 output unchanged one edge after mute", fsync_o, 1);
    @(negedge clk);
    chk(fsync_o == 1'b0 && eflag_o == 1'b0, "R8 outputs low two edges after mute", {fsync_o, eflag_o}, 0);
    wait_m(0);
    for (int i = 0; i < DIV; i++) begin
      if (i > 0) @(negedge clk);
      if (fsync_o !== 1'b0 || eflag_o !== 1'b0) bad++;
    end
    chk(bad == 0, "R8 outputs held low for a whole frame", bad, 0);
    wait_m(HALF + 10);
    send_cmd(8'h0B, 1'b1);
    chk(fsync_o == 1'b0, "R9 still low one edge after release", fsync_o, 0);
    @(negedge clk);
    chk(fsync_o == 1'b1 && eflag_o == 1'b1, "R9 outputs back with phase kept", {fsync_o, eflag_o}, 3);
    frame_case(2, 3, "R9 R5 R6 after release");
  endtask

  task automatic t_ignore();
    wait_m(200);
    send_cmd(8'h0C, 1'b1);
    send_cmd(8'h0A, 1'b0);
    send_cmd(8'hFF, 1'b1);
    @(negedge clk);
    chk(fsync_o == 1'b0, "R10 sync low in low half after ignored commands", fsync_o, 0);
    frame_case(3, 1, "R10 R6 R4 after ignored commands");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    frame_case(1, 2, "R2 R4 R5 R7");
    frame_case(2, 1, "R2 R5 R4 R7");
    frame_case(3, 0, "R2 R6 R3 R7");
    frame_case(0, 3, "R2 R3 R6 R7");
    frame_case(1, 1, "R4 R7");
    frame_case(0, 0, "R3 R7");
    t_mute();
    t_ignore();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule